// File: doc/BRIEF.md
# Flag-Producing 32-Bit Multiply Unit

This block performs one 32x32 multiply per request and reports the result words together with the carry and overflow flags. A 2-bit form selector picks one of four multiply flavours. Unsigned widening and signed widening produce a full double-width product split into a low and a high word. The two signed truncating forms keep only the low word: one takes its second factor from a register, the other from an immediate. Operand fetch and register writeback stay with the surrounding datapath. The unit only sees two operand words and returns results with a write enable for the high word.

A request is a one-cycle `start` pulse carrying the form selector and both operands. The unit registers the operands, registers the product in the next cycle, and registers results and flags in the cycle after that. `done` then pulses high for one cycle. No other arithmetic flag is produced. Carry and overflow always leave the unit with the same value, but the rule behind them depends on the form.

Top module: `mulf_unit`

## Requirements
- R1: After reset, `done`, `hi_we`, `cf`, `of`, `res_lo` and `res_hi` are all 0.
- R2: With `op` = 2'b00 (unsigned widening), `res_lo` and `res_hi` are bits 31:0 and 63:32 of the unsigned 64-bit product of `src_a` and `src_b`, and `hi_we` is 1.
- R3: With `op` = 2'b00, `cf` and `of` are 1 exactly when bits 63:32 of the product are nonzero.
- R4: With `op` = 2'b01 (signed widening), `res_lo` and `res_hi` are the low and high words of the two's complement 64-bit product, and `hi_we` is 1.
- R5: With `op` = 2'b01, `cf` and `of` are 0 only when the high word is all zeros and bit 31 of the low word is 0, or the high word is all ones and bit 31 of the low word is 1; otherwise both are 1.
- R6: With `op` = 2'b10 (truncating, register factor) or 2'b11 (truncating, immediate factor), `res_lo` is the low 32 bits of the signed product, `res_hi` is 0 and `hi_we` is 0.
- R7: With `op` = 2'b10 or 2'b11, `cf` and `of` are 1 exactly when the full signed 64-bit product differs from the sign extension of `res_lo`.
- R8: Whenever `done` is 1, `cf` equals `of`.
- R9: A start that the unit accepts at a clock edge raises `done` at the second clock edge after it, so `done` is high during the third cycle. `done` stays high for exactly one cycle.
- R10: A `start` seen while a request is in flight is ignored. It produces no extra `done`, and the results stay those of the accepted request. A `start` in the cycle where `done` is high is accepted.
- R11: Between `done` pulses, `res_lo`, `res_hi`, `hi_we`, `cf` and `of` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, one cycle |
| op | input | 2 | Form: 00 unsigned wide, 01 signed wide, 10 signed truncating, 11 signed truncating with immediate |
| src_a | input | 32 | First factor |
| src_b | input | 32 | Second factor (register value or immediate) |
| res_lo | output | 32 | Low result word |
| res_hi | output | 32 | High result word (0 for truncating forms) |
| hi_we | output | 1 | High-word write enable |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| done | output | 1 | Result valid, one-cycle pulse |

## Verification
The assertions check on every cycle these properties:
- the two flags agree whenever a result is presented;
- `done` comes at the fixed latency and never lasts two cycles;
- truncating forms never assert the high-word enable;
- the outputs hold still between results.

Only the directed scenarios can show whether the product words and flag values are numerically right. They cover the boundaries between a set and a cleared flag: a product of exactly 2^31, an all-ones high word, and the most negative operand. They also check that a start arriving mid-flight is really dropped.

// File: rtl/mulf_pkg.sv
package mulf_pkg;
  typedef enum logic [1:0] {
    OP_UWIDE      = 2'b00,
    OP_SWIDE      = 2'b01,
    OP_STRUNC     = 2'b10,
    OP_STRUNC_IMM = 2'b11
  } mul_op_e;
endpackage

// File: rtl/mulf_opnd_prep.sv
// Extends both factors to double width: zero-extend for the unsigned form,
// sign-extend for all signed forms, so one multiplier serves every form.
module mulf_opnd_prep
  import mulf_pkg::*;
#(
  parameter int W = 32
) (
  input  mul_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] a_ext,
  output logic [2*W-1:0] b_ext
);
  logic sgn;

  always_comb begin
    sgn   = (op != OP_UWIDE);
    a_ext = {{W{sgn & a[W-1]}}, a};
    b_ext = {{W{sgn & b[W-1]}}, b};
  end
endmodule

// File: rtl/mulf_core.sv
// Registered double-width multiply; the product register carries no reset
// so it can be absorbed into a hard multiplier's output register.
module mulf_core #(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [PW-1:0] a_ext,
  input  logic [PW-1:0] b_ext,
  output logic [PW-1:0] prod,
  output logic          out_valid
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) prod <= a_ext * b_ext;
  end
endmodule

// File: rtl/mulf_flags.sv
// Per-form flag rules and high-word selection.
module mulf_flags
  import mulf_pkg::*;
#(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  mul_op_e       op,
  input  logic [PW-1:0] prod,
  output logic [W-1:0]  hi_word,
  output logic          hi_en,
  output logic          cf_n,
  output logic          of_n
);
  logic [W-1:0] hi, lo;
  logic         hi_nz, hi_fits, sext_ok;

  always_comb begin
    hi      = prod[PW-1:W];
    lo      = prod[W-1:0];
    hi_nz   = |hi;
    // high word is a pure sign extension of the low word's top bit
    hi_fits = ((&hi) & lo[W-1]) | (~hi_nz & ~lo[W-1]);
    // full product matches the sign-extended low word
    sext_ok = (prod == {{W{lo[W-1]}}, lo});
    unique case (op)
      OP_UWIDE: begin
        hi_word = hi; hi_en = 1'b1; cf_n = hi_nz;    of_n = hi_nz;
      end
      OP_SWIDE: begin
        hi_word = hi; hi_en = 1'b1; cf_n = ~hi_fits; of_n = ~sext_ok;
      end
      default: begin
        hi_word = '0; hi_en = 1'b0; cf_n = ~sext_ok; of_n = ~hi_fits;
      end
    endcase
  end
endmodule

// File: rtl/mulf_unit.sv
module mulf_unit
  import mulf_pkg::*;
#(
  parameter int W = 32,
  localparam int PW = 2 * W,
  localparam int LAT_W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi,
  output logic         hi_we,
  output logic         cf,
  output logic         of,
  output logic         done
);
  logic             busy, s1_v, s2_v, accept;
  logic [LAT_W-1:0] lat_cnt;
  logic [W-1:0]     a_q, b_q;
  mul_op_e          op_q;
  logic [PW-1:0]    a_ext, b_ext, prod;
  logic [W-1:0]     f_hi;
  logic             f_we, f_cf, f_of;

  assign accept = start & ~busy;

  // Stage 1: capture the request
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      s1_v    <= 1'b0;
      lat_cnt <= '0;
      a_q     <= '0;
      b_q     <= '0;
      op_q    <= OP_UWIDE;
    end else begin
      s1_v <= accept;
      if (accept) begin
        a_q     <= src_a;
        b_q     <= src_b;
        op_q    <= mul_op_e'(op);
        busy    <= 1'b1;
        lat_cnt <= '0;
      end else begin
        if (s2_v) busy <= 1'b0;
        if (busy) lat_cnt <= lat_cnt + 1'b1;
      end
    end
  end

  mulf_opnd_prep #(.W(W)) u_prep (
    .op(op_q), .a(a_q), .b(b_q), .a_ext(a_ext), .b_ext(b_ext)
  );

  // Stage 2: product
  mulf_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .in_valid(s1_v),
    .a_ext(a_ext), .b_ext(b_ext), .prod(prod), .out_valid(s2_v)
  );

  mulf_flags #(.W(W)) u_flags (
    .op(op_q), .prod(prod), .hi_word(f_hi), .hi_en(f_we),
    .cf_n(f_cf), .of_n(f_of)
  );

  // Stage 3: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      res_lo <= '0;
      res_hi <= '0;
      hi_we  <= 1'b0;
      cf     <= 1'b0;
      of     <= 1'b0;
    end else begin
      done <= s2_v;
      if (s2_v) begin
        res_lo <= prod[W-1:0];
        res_hi <= f_hi;
        hi_we  <= f_we;
        cf     <= f_cf;
        of     <= f_of;
      end
    end
  end

  assert_flags_agree_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cf == of));

  assert_fixed_latency_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == LAT_W'(2)));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_no_hi_write_R6: assert property (@(posedge clk) disable iff (rst)
    (done && op_q[1]) |-> (!hi_we && res_hi == '0));

  assert_outputs_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_lo) && $stable(res_hi) && $stable(hi_we)
               && $stable(cf) && $stable(of)));
endmodule

// File: tb/test_mulf_unit.sv
module test_mulf_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, start;
  logic [1:0]  op;
  logic [31:0] src_a, src_b, res_lo, res_hi;
  logic        hi_we, cf, of, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  mulf_unit i_mulf_unit (
    .clk(clk), .rst(rst), .start(start), .op(op), .src_a(src_a), .src_b(src_b),
    .res_lo(res_lo), .res_hi(res_hi), .hi_we(hi_we), .cf(cf), .of(of), .done(done)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Drive one accepted request, wait for done, return the cycles taken.
  task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                       output int cyc);
    @(negedge clk);
    start = 1'b1; op = o; src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // Run a vector and compare against a model built from the requirements.
  task automatic run_vec(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    int cyc;
    logic [63:0] full;
    logic [31:0] elo, ehi;
    logic        ewe, eflag;
    string rp, rf;
    if (o == 2'b00) full = {32'h0, a} * {32'h0, b};
    else            full = {{32{a[31]}}, a} * {{32{b[31]}}, b};
    elo = full[31:0];
    case (o)
      2'b00: begin
        rp = "R2"; rf = "R3"; ehi = full[63:32]; ewe = 1'b1;
        eflag = (full[63:32] != 0);
      end
      2'b01: begin
        rp = "R4"; rf = "R5"; ehi = full[63:32]; ewe = 1'b1;
        eflag = !((full[63:32] == 32'hffffffff && full[31]) ||
                  (full[63:32] == 32'h0 && !full[31]));
      end
      default: begin
        rp = "R6"; rf = "R7"; ehi = 32'h0; ewe = 1'b0;
        eflag = (full != {{32{elo[31]}}, elo});
      end
    endcase
    issue(o, a, b, cyc);
    check("R9", "latency", 64'(cyc), 64'd3);
    check(rp, "res_lo", 64'(res_lo), 64'(elo));
    check(rp, "res_hi", 64'(res_hi), 64'(ehi));
    check(rp, "hi_we", 64'(hi_we), 64'(ewe));
    check(rf, "cf", 64'(cf), 64'(eflag));
    check(rf, "of", 64'(of), 64'(eflag));
    check("R8", "cf==of", 64'(cf), 64'(of));
    @(negedge clk);
    check("R9", "done one cycle", 64'(done), 64'd0);
    check("R11", "res_lo hold", 64'(res_lo), 64'(elo));
    check("R11", "flag hold", 64'(cf), 64'(eflag));
  endtask

  task automatic t_reset();
    check("R1", "done", 64'(done), 64'd0);
    check("R1", "res_lo", 64'(res_lo), 64'd0);
    check("R1", "res_hi", 64'(res_hi), 64'd0);
    check("R1", "hi_we", 64'(hi_we), 64'd0);
    check("R1", "cf", 64'(cf), 64'd0);
    check("R1", "of", 64'(of), 64'd0);
  endtask

  task automatic t_unsigned();
    run_vec(2'b00, 32'd2, 32'd3);
    run_vec(2'b00, 32'hffffffff, 32'hffffffff);
    run_vec(2'b00, 32'h00010000, 32'h00010000);
    run_vec(2'b00, 32'h80000000, 32'd1);
    run_vec(2'b00, 32'h80000000, 32'd2);
  endtask

  task automatic t_signed_wide();
    run_vec(2'b01, 32'hffffffff, 32'hffffffff);
    run_vec(2'b01, 32'hfffffffe, 32'd3);
    run_vec(2'b01, 32'h40000000, 32'd2);
    run_vec(2'b01, 32'h80000000, 32'h80000000);
    run_vec(2'b01, 32'h80000000, 32'd1);
    run_vec(2'b01, 32'h0, 32'h80000000);
  endtask

  task automatic t_truncating();
    run_vec(2'b10, 32'd7, 32'hfffffff7);
    run_vec(2'b10, 32'h00010000, 32'h00010000);
    run_vec(2'b10, 32'hffffffff, 32'h80000000);
    run_vec(2'b11, 32'h0000ffff, 32'h00008001);
    run_vec(2'b11, 32'hc0000000, 32'd1);
    run_vec(2'b11, 32'h40000000, 32'd2);
  endtask

  // R10: a second start during flight is dropped.
  task automatic t_busy_ignore();
    int dones = 0;
    @(negedge clk);
    start = 1'b1; op = 2'b00; src_a = 32'd5; src_b = 32'd6;
    @(negedge clk);
    op = 2'b01; src_a = 32'hffffffff; src_b = 32'h7;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (done) begin
        dones++;
        check("R10", "res_lo first op", 64'(res_lo), 64'd30);
        check("R10", "res_hi first op", 64'(res_hi), 64'd0);
      end
      @(negedge clk);
    end
    check("R10", "done count", 64'(dones), 64'd1);
  endtask

  // R10: start in the done cycle is accepted.
  task automatic t_back_to_back();
    int cyc;
    issue(2'b00, 32'd4, 32'd4, cyc);
    check("R9", "latency", 64'(cyc), 64'd3);
    start = 1'b1; op = 2'b10; src_a = 32'd9; src_b = 32'd9;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    check("R10", "accepted in done cycle latency", 64'(cyc), 64'd3);
    check("R10", "second result", 64'(res_lo), 64'd81);
    check("R6", "hi_we truncating", 64'(hi_we), 64'd0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; start = 1'b0; op = 2'b00; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed_wide();
    t_truncating();
    t_busy_ignore();
    t_back_to_back();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule